// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level radix page table kept in memory. A requester hands it a virtual address together with the kind of access (read or write) and the privilege of the requester (user or supervisor). The walker takes the physical frame of the top-level table (the directory) from a root input. It fetches one directory entry and then one table entry over a simple word-read memory port, and returns either the translated address or a fault code naming the level that failed.

The top ten bits of the virtual address index the directory, the next ten bits index the second-level table, and the low twelve bits pass straight through as the page offset. Every table fills one 4 KB page of 4-byte entries. Each entry carries a 20-bit frame number in its upper bits and three flag bits at the bottom. Every address the walker puts out on the memory port is physical. One walk runs at a time. A new request is taken only after the previous response has been consumed.

Top module: `pt_walker`

## Requirements
- R1: When a request is accepted, the first memory read goes to the address formed by the root frame in bits 31:12, the virtual address bits 31:22 in bits 11:2, and zeros in bits 1:0.
- R2: The second memory read goes to the address formed by the directory entry's bits 31:12 in bits 31:12, the virtual address bits 21:12 in bits 11:2, and zeros in bits 1:0.
- R3: A walk with no fault responds with fault code 0 and a physical address made of the table entry's bits 31:12 followed by the virtual address bits 11:0.
- R4: A directory entry whose bit 0 (present) is clear gives fault code 1 (not present) at level 0, and no second memory read is issued.
- R5: A table entry whose bit 0 is clear gives fault code 1 at level 1.
- R6: A write access to an entry whose bit 1 (writable) is clear gives fault code 2 (protection) at that entry's level, whatever the privilege. A write is allowed only when bit 1 is set at both levels.
- R7: A user access to an entry whose bit 2 (user) is clear gives fault code 2 at that entry's level. A supervisor access ignores bit 2.
- R8: req_ready is high only while no walk is in progress and no response is pending. rsp_valid, and with it rsp_paddr, rsp_fault and rsp_level, stays unchanged until rsp_ready is seen high.
- R9: mem_req stays high with mem_addr unchanged until mem_rvalid is seen, and mem_rvalid may arrive in the same cycle as mem_req or any number of cycles later.
- R10: A directory-level fault is reported before anything at the table level. Within one level, not present takes priority over protection.
- R11: After reset, req_ready is 1, rsp_valid is 0 and mem_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| root_frame | input | 20 | Physical frame of the directory page, sampled when a request is accepted |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | 32 | Physical address of the entry being read |
| mem_rvalid | input | 1 | Read data valid, completes the pending read |
| mem_rdata | input | 32 | Entry word read from memory |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Requester consumes the response |
| rsp_paddr | output | 32 | Translated physical address (0 on a fault) |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 protection |
| rsp_level | output | 1 | Level that faulted: 0 directory, 1 table |

## Verification
The bench goes after the index extremes (directory and table index 0 and 1023, offset 0xfff). A design that shifts or drops an index bit reads the wrong entry there and returns a wrong address. It places a clear writable or user bit at each level in turn. A design that checks only the final entry would grant access through a read-only or supervisor-only directory, and one that reports the wrong level would be seen at once. It also combines a missing present bit with missing permission bits to catch faults reported in the wrong priority, checks that no second read follows a directory fault, and varies the memory latency from zero to several cycles while holding off the response. This catches a walker that drops its request early, reads stale data or lets its response change while stalled.

// File: rtl/ptw_pkg.sv
// Package: shared types and constants for the two-level page table walker.
// Assumes entries carry their flags in the lowest three bits.
package ptw_pkg;

    // Flag bit positions inside a page table entry.
    localparam int FLAG_PRESENT  = 0;
    localparam int FLAG_WRITABLE = 1;
    localparam int FLAG_USER     = 2;
    localparam int FLAG_BITS     = 3;

    // Fault codes returned with a response.
    typedef enum logic [1:0] {
        FLT_NONE        = 2'd0,
        FLT_NOT_PRESENT = 2'd1,
        FLT_PROTECT     = 2'd2
    } fault_e;

    // Walk sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_READ_DIR  = 3'd1,
        ST_CHECK_DIR = 3'd2,
        ST_READ_TBL  = 3'd3,
        ST_CHECK_TBL = 3'd4,
        ST_DONE      = 3'd5
    } walk_state_e;

endpackage

// File: rtl/ptw_entry_addr.sv
// Module: forms the physical address of one page table entry from the
// frame of the table page and the index into it.
// Assumes IDX_W + ENTRY_LOG2 does not exceed OFF_BITS (a table fits one page).
module ptw_entry_addr #(
    parameter int FRAME_W    = 20,
    parameter int OFF_BITS   = 12,
    parameter int IDX_W      = 10,
    parameter int ENTRY_LOG2 = 2
) (
    input  logic [FRAME_W-1:0]          table_frame,
    input  logic [IDX_W-1:0]            index,
    output logic [FRAME_W+OFF_BITS-1:0] entry_addr
);
    localparam int SCALED_W = IDX_W + ENTRY_LOG2;

    logic [SCALED_W-1:0] scaled;
    logic [OFF_BITS-1:0] byte_off;

    // Scale the index by the entry size and place it under the frame.
    always_comb begin
        scaled     = {index, {ENTRY_LOG2{1'b0}}};
        byte_off   = OFF_BITS'(scaled);
        entry_addr = {table_frame, byte_off};
    end
endmodule

// File: rtl/ptw_perm_check.sv
// Module: decides whether one entry's flags permit the requested access.
// Writes need the writable flag at any privilege; user accesses need the
// user flag. Presence is reported separately so the caller can rank faults.
module ptw_perm_check
    import ptw_pkg::*;
(
    input  logic [FLAG_BITS-1:0] flags,
    input  logic                 is_write,
    input  logic                 is_user,
    output logic                 present,
    output logic                 allowed
);
    // Evaluate presence and permission for a single level.
    always_comb begin
        present = flags[FLAG_PRESENT];
        allowed = (!is_write || flags[FLAG_WRITABLE]) &&
                  (!is_user  || flags[FLAG_USER]);
    end
endmodule

// File: rtl/pt_walker.sv
// Module: two-level page table walker. Accepts one translation request,
// reads the directory entry and then the table entry through a word-read
// memory port, checks presence and permission at each level, and holds a
// response (physical address or fault code plus level) until consumed.
// Assumes the memory port returns exactly one mem_rvalid per read, only
// while mem_req is high.
module pt_walker
    import ptw_pkg::*;
#(
    parameter int PA_W       = 32,
    parameter int OFF_BITS   = 12,
    parameter int DIR_BITS   = 10,
    parameter int TBL_BITS   = 10,
    parameter int ENTRY_LOG2 = 2,
    parameter int VA_W       = DIR_BITS + TBL_BITS + OFF_BITS,
    parameter int FRAME_W    = PA_W - OFF_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] root_frame,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic               req_write,
    input  logic               req_user,
    output logic               mem_req,
    output logic [PA_W-1:0]    mem_addr,
    input  logic               mem_rvalid,
    input  logic [PA_W-1:0]    mem_rdata,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic [1:0]         rsp_fault,
    output logic               rsp_level
);
    localparam int LEVELS = 2;
    localparam int IDX_W  = (DIR_BITS > TBL_BITS) ? DIR_BITS : TBL_BITS;
    localparam int TBL_LO = OFF_BITS;
    localparam int DIR_LO = OFF_BITS + TBL_BITS;

    walk_state_e          state_q;
    logic [VA_W-1:0]      vaddr_q;
    logic                 write_q;
    logic                 user_q;
    logic [FRAME_W-1:0]   root_q;
    logic [FRAME_W-1:0]   dir_frame_q;
    logic [FLAG_BITS-1:0] dir_flags_q;
    logic [FRAME_W-1:0]   tbl_frame_q;
    logic [FLAG_BITS-1:0] tbl_flags_q;
    fault_e               fault_q;
    logic                 level_q;
    logic [PA_W-1:0]      paddr_q;

    logic [IDX_W-1:0]     lvl_index [LEVELS];
    logic [FRAME_W-1:0]   lvl_frame [LEVELS];
    logic [FLAG_BITS-1:0] lvl_flags [LEVELS];
    logic [PA_W-1:0]      lvl_addr  [LEVELS];
    logic                 lvl_present [LEVELS];
    logic                 lvl_allowed [LEVELS];

    logic                 unused_entry_bits;

    // Bits of a fetched entry between the flags and the frame are not used.
    assign unused_entry_bits = ^mem_rdata[OFF_BITS-1:FLAG_BITS];

    // Per-level inputs: index slice, table frame and the entry's flags.
    always_comb begin
        lvl_index[0] = IDX_W'(vaddr_q[DIR_LO +: DIR_BITS]);
        lvl_index[1] = IDX_W'(vaddr_q[TBL_LO +: TBL_BITS]);
        lvl_frame[0] = root_q;
        lvl_frame[1] = dir_frame_q;
        lvl_flags[0] = dir_flags_q;
        lvl_flags[1] = tbl_flags_q;
    end

    // One address former and one permission checker per level.
    for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_level
        ptw_entry_addr #(
            .FRAME_W    (FRAME_W),
            .OFF_BITS   (OFF_BITS),
            .IDX_W      (IDX_W),
            .ENTRY_LOG2 (ENTRY_LOG2)
        ) u_entry_addr (
            .table_frame (lvl_frame[lvl]),
            .index       (lvl_index[lvl]),
            .entry_addr  (lvl_addr[lvl])
        );

        ptw_perm_check u_perm (
            .flags    (lvl_flags[lvl]),
            .is_write (write_q),
            .is_user  (user_q),
            .present  (lvl_present[lvl]),
            .allowed  (lvl_allowed[lvl])
        );
    end

    // Walk sequencer: accept, fetch each level, check, hold the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            vaddr_q     <= '0;
            write_q     <= 1'b0;
            user_q      <= 1'b0;
            root_q      <= '0;
            dir_frame_q <= '0;
            dir_flags_q <= '0;
            tbl_frame_q <= '0;
            tbl_flags_q <= '0;
            fault_q     <= FLT_NONE;
            level_q     <= 1'b0;
            paddr_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        write_q <= req_write;
                        user_q  <= req_user;
                        root_q  <= root_frame;
                        state_q <= ST_READ_DIR;
                    end
                end
                ST_READ_DIR: begin
                    if (mem_rvalid) begin
                        dir_frame_q <= mem_rdata[PA_W-1:OFF_BITS];
                        dir_flags_q <= mem_rdata[FLAG_BITS-1:0];
                        state_q     <= ST_CHECK_DIR;
                    end
                end
                ST_CHECK_DIR: begin
                    level_q <= 1'b0;
                    paddr_q <= '0;
                    if (!lvl_present[0]) begin
                        fault_q <= FLT_NOT_PRESENT;
                        state_q <= ST_DONE;
                    end else if (!lvl_allowed[0]) begin
                        fault_q <= FLT_PROTECT;
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_READ_TBL;
                    end
                end
                ST_READ_TBL: begin
                    if (mem_rvalid) begin
                        tbl_frame_q <= mem_rdata[PA_W-1:OFF_BITS];
                        tbl_flags_q <= mem_rdata[FLAG_BITS-1:0];
                        state_q     <= ST_CHECK_TBL;
                    end
                end
                ST_CHECK_TBL: begin
                    level_q <= 1'b1;
                    state_q <= ST_DONE;
                    if (!lvl_present[1]) begin
                        fault_q <= FLT_NOT_PRESENT;
                        paddr_q <= '0;
                    end else if (!lvl_allowed[1]) begin
                        fault_q <= FLT_PROTECT;
                        paddr_q <= '0;
                    end else begin
                        fault_q <= FLT_NONE;
                        level_q <= 1'b0;
                        paddr_q <= {tbl_frame_q, vaddr_q[OFF_BITS-1:0]};
                    end
                end
                ST_DONE: begin
                    if (rsp_ready) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port decode from the walk state and held results.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_req   = (state_q == ST_READ_DIR) || (state_q == ST_READ_TBL);
        mem_addr  = (state_q == ST_READ_TBL) ? lvl_addr[1] : lvl_addr[0];
        rsp_valid = (state_q == ST_DONE);
        rsp_paddr = paddr_q;
        rsp_fault = fault_q;
        rsp_level = level_q;
    end

    // R1: an accepted request opens a directory read in the root frame.
    assert_dir_read_in_root_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=>
            (mem_req && mem_addr[PA_W-1:OFF_BITS] == $past(root_frame)));

    // R9: a pending read keeps its request and address until data returns.
    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R8: a stalled response does not change.
    assert_rsp_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_level)));

    // R3: a fault-free response carries the request's page offset.
    assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_NONE) |->
            (rsp_paddr[OFF_BITS-1:0] == vaddr_q[OFF_BITS-1:0]));

    // R4: a directory-level fault never follows a table read.
    assert_dir_fault_no_table_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid && !mem_rdata[FLAG_PRESENT] && state_q == ST_READ_DIR) |=>
            ##1 (rsp_valid && rsp_fault == FLT_NOT_PRESENT && !rsp_level));

    // R8: the response code is always a defined value.
    assert_fault_code_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault != 2'd3));
endmodule

// File: tb/pt_walker_bench.sv
// Directed bench for pt_walker: sparse word memory, one task per scenario.
module pt_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] root_frame = 20'hffff1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        rsp_level;

    int n_checks = 0;
    int n_fails  = 0;
    int latency  = 0;
    int n_reads  = 0;
    logic [31:0] read_log [4];
    logic [31:0] mem_a [24];
    logic [31:0] mem_d [24];
    int mem_n = 0;

    logic [31:0] got_paddr;
    logic [1:0]  got_fault;
    logic        got_level;

    always #10 clk = ~clk;

    pt_walker u_pt_walker (
        .clk(clk), .rst_n(rst_n), .root_frame(root_frame),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_level(rsp_level)
    );

    function automatic logic [31:0] mem_lookup(input logic [31:0] a);
        for (int i = 0; i < mem_n; i++) if (mem_a[i] == a) return mem_d[i];
        return 32'h0;
    endfunction

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        mem_a[mem_n] = a;
        mem_d[mem_n] = d;
        mem_n++;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Memory responder with programmable latency, acting at falling edges.
    initial begin
        int waited = 0;
        forever begin
            @(negedge clk);
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
            end else if (mem_req) begin
                if (waited >= latency) begin
                    mem_rdata  = mem_lookup(mem_addr);
                    mem_rvalid = 1'b1;
                    if (n_reads < 4) read_log[n_reads] = mem_addr;
                    n_reads++;
                    waited = 0;
                end else begin
                    waited++;
                end
            end
        end
    end

    // Run one walk; hold the response for 'hold' cycles before consuming it.
    task automatic walk(input logic [31:0] va, input logic wr, input logic usr,
                        input int lat, input int hold);
        latency = lat;
        n_reads = 0;
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        got_paddr = rsp_paddr; got_fault = rsp_fault; got_level = rsp_level;
        for (int i = 0; i < hold; i++) begin
            req_valid = 1'b1;
            @(negedge clk);
            check("R8 rsp_valid held", {31'b0, rsp_valid}, 32'd1);
            check("R8 paddr held", rsp_paddr, got_paddr);
            check("R8 req_ready low while pending", {31'b0, req_ready}, 32'd0);
        end
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        check("R8 rsp_valid drops after consume", {31'b0, rsp_valid}, 32'd0);
        check("R8 ready again", {31'b0, req_ready}, 32'd1);
    endtask

    task automatic expect_ok(input string tag, input logic [31:0] pa);
        check({tag, " fault"}, {30'b0, got_fault}, 32'd0);
        check({tag, " paddr"}, got_paddr, pa);
    endtask

    task automatic expect_fault(input string tag, input logic [1:0] code, input logic lvl,
                                input int reads);
        check({tag, " fault"}, {30'b0, got_fault}, {30'b0, code});
        check({tag, " level"}, {31'b0, got_level}, {31'b0, lvl});
        check({tag, " read count"}, n_reads, reads);
    endtask

    task automatic t_reset;
        check("R11 req_ready", {31'b0, req_ready}, 32'd1);
        check("R11 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check("R11 mem_req", {31'b0, mem_req}, 32'd0);
    endtask

    task automatic t_basic_vector;
        walk(32'h0000_0000, 1'b0, 1'b1, 0, 0);
        check("R1 directory read addr", read_log[0], 32'hffff1000);
        check("R2 table read addr", read_log[1], 32'hf0f02000);
        expect_ok("R3 zero vector", 32'hffff5000);
    endtask

    task automatic t_mid_latency;
        walk(32'h00C0_5123, 1'b1, 1'b1, 2, 3);
        check("R1 dir addr idx3", read_log[0], 32'hffff100C);
        check("R2 tbl addr idx5", read_log[1], 32'h12345014);
        expect_ok("R3 R9 latency 2", 32'habcde123);
    endtask

    task automatic t_extremes;
        walk(32'hFFFF_FFFF, 1'b0, 1'b0, 0, 1);
        check("R1 dir addr idx max", read_log[0], 32'hffff1ffc);
        check("R2 tbl addr idx max", read_log[1], 32'h55555ffc);
        expect_ok("R3 extremes", 32'h66666fff);
    endtask

    task automatic t_not_present;
        walk(32'h0080_0000, 1'b0, 1'b0, 1, 0);
        expect_fault("R4 dir absent", 2'd1, 1'b0, 1);
        walk(32'h0100_0000, 1'b0, 1'b0, 0, 0);
        expect_fault("R5 tbl absent", 2'd1, 1'b1, 2);
    endtask

    task automatic t_write_perm;
        walk(32'h0140_0000, 1'b1, 1'b0, 0, 0);
        expect_fault("R6 dir read-only write", 2'd2, 1'b0, 1);
        walk(32'h0140_0000, 1'b0, 1'b1, 0, 0);
        expect_ok("R6 dir read-only read", 32'h77777000);
        walk(32'h0180_0000, 1'b1, 1'b0, 3, 0);
        expect_fault("R6 tbl read-only supervisor write", 2'd2, 1'b1, 2);
    endtask

    task automatic t_user_perm;
        walk(32'h01C0_0000, 1'b0, 1'b1, 0, 0);
        expect_fault("R7 dir supervisor-only user read", 2'd2, 1'b0, 1);
        walk(32'h01C0_0000, 1'b0, 1'b0, 0, 0);
        expect_ok("R7 supervisor ignores user bit", 32'hbbbbb000);
        walk(32'h0200_0000, 1'b0, 1'b1, 0, 0);
        expect_fault("R7 tbl supervisor-only user read", 2'd2, 1'b1, 2);
    endtask

    task automatic t_priority;
        walk(32'h0240_0000, 1'b1, 1'b1, 0, 0);
        expect_fault("R10 dir absent over protect", 2'd1, 1'b0, 1);
        walk(32'h0100_1000, 1'b1, 1'b1, 0, 0);
        expect_fault("R10 tbl absent over protect", 2'd1, 1'b1, 2);
        walk(32'h0140_1000, 1'b1, 1'b1, 0, 0);
        expect_fault("R10 dir protect before tbl", 2'd2, 1'b0, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        poke(32'hffff1000, 32'hf0f02007); poke(32'hf0f02000, 32'hffff5007);
        poke(32'hffff100C, 32'h12345007); poke(32'h12345014, 32'habcde007);
        poke(32'hffff1ffc, 32'h55555007); poke(32'h55555ffc, 32'h66666007);
        poke(32'hffff1010, 32'h22222007); poke(32'h22222000, 32'h33333006);
        poke(32'h22222004, 32'h00000000);
        poke(32'hffff1014, 32'h44444005); poke(32'h44444000, 32'h77777007);
        poke(32'h44444004, 32'h00000000);
        poke(32'hffff1018, 32'h88888007); poke(32'h88888000, 32'h99999005);
        poke(32'hffff101c, 32'haaaaa003); poke(32'haaaaa000, 32'hbbbbb003);
        poke(32'hffff1020, 32'hccccc007); poke(32'hccccc000, 32'hddddd003);
        poke(32'hffff1024, 32'heeeee006);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_vector();
        t_mid_latency();
        t_extremes();
        t_not_present();
        t_write_perm();
        t_user_perm();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule